// File: doc/BRIEF.md
# Serial Signed Decimal Field Adder

This block adds a signed decimal field A into a signed decimal field B. Both fields sit in a character-wide memory. Each character is six bits wide and holds one decimal digit in its low nibble. A field is named by the address of its leftmost character and by a short length code. The block reads both operands one character at a time, starting at the least significant (rightmost) end. It works out the algebraic sum serially, one digit per cycle, and then writes the result back over B, again from right to left.

When the signs differ, the block subtracts. It forms the ten's complement and, if the difference comes out negative, it complements the result a second time. The result carries the sign of the operand with the larger magnitude. A result with too many digits for B is cut to B's length and raises an overflow flag. A digit code above nine, or a bad length code, stops the operation before any write. In that case the error flag is raised.

A user drives the two start addresses and the two length codes, then pulses `start`. The user waits for the one-cycle `done` pulse and then reads the flags. The flags hold their values until the next accepted start.

Top module: `sbcd_field_adder`

## Requirements
- R1: Character layout. Bits [3:0] hold the digit. On the rightmost character of a field, bit 5 is the sign (1 = negative). Bit 4 is a zone bit. The block reads every character of A, then every character of B, and only after all reads does it write any character. Each field is read and written from its rightmost address (start + length − 1) down to its start address. A read returns data one cycle after `mem_rd`.
- R2: A length code is 4 bits wide. The codes 1 to 9 give that many characters, and code 0 gives ten characters. Any code of 10 to 15 ends the operation with `err`=1 and makes no memory access.
- R3: When the two signs are equal, the magnitudes are added and the result keeps that sign.
- R4: When the signs differ, the result is the difference of the magnitudes and takes the sign of the larger one. For example, A = −1 added into B = 8 gives 7.
- R5: A result of zero is always stored and reported as positive.
- R6: When A is shorter than B, the missing high-order digits of A count as zero.
- R7: When the true result magnitude is 10^lenB or more, `ovf`=1 and B receives the low lenB digits of the magnitude. Otherwise `ovf`=0.
- R8: Every character written has bits [5:4] = 00, except that bit 5 of B's rightmost character carries the result sign. The zone bits of the input characters have no effect on the result.
- R9: A digit above 9 in either operand sets `err`=1, clears `ovf` and `res_neg`, and leaves memory unchanged.
- R10: Field A is never written. A `start` pulse received while an operation is running is ignored. `done` is a one-cycle pulse with `busy` low, and the memory port is idle whenever `busy` is low.
- R11: `res_neg` equals the sign bit written into B's rightmost character. It holds that value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation when idle |
| a_addr | input | AW | Leftmost character address of A |
| a_len | input | 4 | Length code of A |
| b_addr | input | AW | Leftmost character address of B |
| b_len | input | 4 | Length code of B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_neg | output | 1 | Sign of the stored result |
| ovf | output | 1 | Result truncated to B's length |
| err | output | 1 | Illegal digit or length code |
| mem_addr | output | AW | Memory character address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 6 | Character to write |
| mem_rdata | input | 6 | Character read, valid one cycle after mem_rd |

## Verification
The assertions check the port protocol on every cycle:
- reads and writes never coincide;
- no read follows a write within one operation;
- the memory port is idle outside `busy`;
- `done` is a single-cycle pulse;
- zone bit 4 is always cleared in written data;
- an errored operation neither writes nor reports a sign or an overflow.

The arithmetic itself can only be shown by the bench scenarios. These cover the sign of the larger magnitude, the recomplement path, a zero stored as positive, overflow truncation, the ten-character length, and inputs whose zone bits are ignored. For each one, the bench compares every written character and the final memory image against a behavioural model.

// File: rtl/sbcd_pkg.sv
package sbcd_pkg;
  localparam int CHAR_W = 6;
  localparam int LCODE_W = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RDREQ,
    S_RDCAP,
    S_CALC,
    S_FIX,
    S_WR,
    S_FIN
  } sbcd_state_e;
endpackage

// File: rtl/sbcd_len_dec.sv
module sbcd_len_dec #(
  parameter int NDIG = 10,
  parameter int IW   = 4
) (
  input  logic [3:0]    code,
  output logic [IW-1:0] len,
  output logic          bad
);
  always_comb begin
    bad = (code > 4'd9);
    len = (code == 4'd0) ? IW'(NDIG) : IW'(code);
  end
endmodule

// File: rtl/sbcd_digit_add.sv
module sbcd_digit_add (
  input  logic [3:0] x,
  input  logic [3:0] y,
  input  logic       sub,
  input  logic       cin,
  output logic [3:0] s,
  output logic       cout
);
  logic [3:0] y_eff;
  logic [4:0] t;
  always_comb begin
    y_eff = sub ? (4'd9 - y) : y;
    t     = 5'(x) + 5'(y_eff) + 5'(cin);
    cout  = (t > 5'd9);
    s     = cout ? 4'(t - 5'd10) : t[3:0];
  end
endmodule

// File: rtl/sbcd_field_adder.sv
module sbcd_field_adder
  import sbcd_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NDIG = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     a_addr,
  input  logic [3:0]        a_len,
  input  logic [AW-1:0]     b_addr,
  input  logic [3:0]        b_len,
  output logic              busy,
  output logic              done,
  output logic              res_neg,
  output logic              ovf,
  output logic              err,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [CHAR_W-1:0] mem_wdata,
  input  logic [CHAR_W-1:0] mem_rdata
);
  localparam int IW = $clog2(NDIG + 1);

  sbcd_state_e   state;
  logic [IW-1:0] cnt, la, lb, la_in, lb_in;
  logic          la_bad, lb_bad;
  logic [AW-1:0] a_base, b_base;
  logic          phase_b, sa, sb, carry, neg_r, ovf_carry;
  logic [3:0]    a_dig [NDIG];
  logic [3:0]    b_dig [NDIG];
  logic [3:0]    r_dig [NDIG];

  logic [3:0]    add_x, add_y, add_s;
  logic          add_sub, add_cin, add_cout;
  logic          nz_lo, nz_hi, sign_out, last_rd;
  logic [IW-1:0] cur_len;
  logic [AW-1:0] rd_addr, wr_addr;

  sbcd_len_dec #(.NDIG(NDIG), .IW(IW)) u_dec_a (.code(a_len), .len(la_in), .bad(la_bad));
  sbcd_len_dec #(.NDIG(NDIG), .IW(IW)) u_dec_b (.code(b_len), .len(lb_in), .bad(lb_bad));

  sbcd_digit_add u_add (
    .x(add_x), .y(add_y), .sub(add_sub), .cin(add_cin), .s(add_s), .cout(add_cout)
  );

  // operand selection: main pass adds A into B, fix pass complements the result
  always_comb begin
    if (state == S_CALC) begin
      add_x   = b_dig[cnt];
      add_y   = a_dig[cnt];
      add_sub = (sa != sb);
    end else begin
      add_x   = 4'd0;
      add_y   = r_dig[cnt];
      add_sub = 1'b1;
    end
    add_cin = (cnt == '0) ? add_sub : carry;
  end

  // nonzero digits inside and above B's length
  always_comb begin
    nz_lo = 1'b0;
    nz_hi = 1'b0;
    for (int i = 0; i < NDIG; i++) begin
      if (r_dig[i] != 4'd0) begin
        if (IW'(i) < lb) nz_lo = 1'b1;
        else             nz_hi = 1'b1;
      end
    end
    sign_out = neg_r && nz_lo;
  end

  always_comb begin
    cur_len  = phase_b ? lb : la;
    last_rd  = (cnt == cur_len - IW'(1));
    rd_addr  = (phase_b ? b_base : a_base) + AW'(cur_len) - AW'(1) - AW'(cnt);
    wr_addr  = b_base + AW'(lb) - AW'(1) - AW'(cnt);
    busy     = (state != S_IDLE) && (state != S_FIN);
    done     = (state == S_FIN);
    mem_rd   = (state == S_RDREQ);
    mem_wr   = (state == S_WR);
    mem_addr = (state == S_WR) ? wr_addr : rd_addr;
    mem_wdata = {(cnt == '0) && sign_out, 1'b0, r_dig[cnt]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      la        <= '0;
      lb        <= '0;
      a_base    <= '0;
      b_base    <= '0;
      phase_b   <= 1'b0;
      sa        <= 1'b0;
      sb        <= 1'b0;
      carry     <= 1'b0;
      neg_r     <= 1'b0;
      ovf_carry <= 1'b0;
      res_neg   <= 1'b0;
      ovf       <= 1'b0;
      err       <= 1'b0;
      for (int i = 0; i < NDIG; i++) begin
        a_dig[i] <= '0;
        b_dig[i] <= '0;
        r_dig[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (start) begin
          a_base    <= a_addr;
          b_base    <= b_addr;
          la        <= la_in;
          lb        <= lb_in;
          cnt       <= '0;
          phase_b   <= 1'b0;
          sa        <= 1'b0;
          sb        <= 1'b0;
          ovf_carry <= 1'b0;
          res_neg   <= 1'b0;
          ovf       <= 1'b0;
          err       <= la_bad || lb_bad;
          for (int i = 0; i < NDIG; i++) begin
            a_dig[i] <= '0;
            b_dig[i] <= '0;
          end
          state <= (la_bad || lb_bad) ? S_FIN : S_RDREQ;
        end
        S_RDREQ: state <= S_RDCAP;
        S_RDCAP: begin
          if (mem_rdata[3:0] > 4'd9) begin
            err   <= 1'b1;
            state <= S_FIN;
          end else begin
            if (phase_b) begin
              b_dig[cnt] <= mem_rdata[3:0];
              if (cnt == '0) sb <= mem_rdata[5];
            end else begin
              a_dig[cnt] <= mem_rdata[3:0];
              if (cnt == '0) sa <= mem_rdata[5];
            end
            if (last_rd) begin
              cnt     <= '0;
              phase_b <= 1'b1;
              state   <= phase_b ? S_CALC : S_RDREQ;
            end else begin
              cnt   <= cnt + IW'(1);
              state <= S_RDREQ;
            end
          end
        end
        S_CALC: begin
          r_dig[cnt] <= add_s;
          carry      <= add_cout;
          if (cnt == IW'(NDIG - 1)) begin
            cnt <= '0;
            if (add_sub && !add_cout) begin
              neg_r <= sa;
              state <= S_FIX;
            end else begin
              neg_r     <= sb;
              ovf_carry <= !add_sub && add_cout;
              state     <= S_WR;
            end
          end else begin
            cnt <= cnt + IW'(1);
          end
        end
        S_FIX: begin
          r_dig[cnt] <= add_s;
          carry      <= add_cout;
          if (cnt == IW'(NDIG - 1)) begin
            cnt   <= '0;
            state <= S_WR;
          end else begin
            cnt <= cnt + IW'(1);
          end
        end
        S_WR: begin
          if (cnt == lb - IW'(1)) begin
            res_neg <= sign_out;
            ovf     <= ovf_carry || nz_hi;
            state   <= S_FIN;
          end else begin
            cnt <= cnt + IW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbcd_field_adder_chk.sv
module sbcd_field_adder_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       res_neg,
  input logic       ovf,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [5:0] mem_wdata
);
  logic wrote;
  always_ff @(posedge clk) begin
    if (rst)                wrote <= 1'b0;
    else if (start && !busy) wrote <= 1'b0;
    else if (mem_wr)        wrote <= 1'b1;
  end

  a_r1_rw_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  a_r1_reads_first: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !wrote);
  a_r8_zone_clear: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata[4] == 1'b0));
  a_r9_err_no_write: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> !wrote);
  a_r9_err_flags: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (!res_neg && !ovf));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r10_port_idle: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> busy);
  a_r10_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind sbcd_field_adder sbcd_field_adder_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err(err),
  .res_neg(res_neg), .ovf(ovf), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
);

// File: tb/sbcd_field_adder_bench.sv
module sbcd_field_adder_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [3:0]    a_len = '0, b_len = '0;
  logic          busy, done, res_neg, ovf, err, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [5:0]    mem_wdata;
  logic [5:0]    mem_rdata = '0;

  logic [5:0] mem     [256];
  logic [5:0] exp_mem [256];
  int  n_chk = 0, n_bad = 0;
  bit  in_op = 1'b0, exp_err = 1'b0, exp_ovf = 1'b0, exp_neg = 1'b0;

  always #5 clk = ~clk;

  sbcd_field_adder #(.AW(AW), .NDIG(10)) u_sbcd_field_adder (
    .clk(clk), .rst(rst), .start(start), .a_addr(a_addr), .a_len(a_len),
    .b_addr(b_addr), .b_len(b_len), .busy(busy), .done(done), .res_neg(res_neg),
    .ovf(ovf), .err(err), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // per-clock comparison of every write against the model image (R1, R8, R9, R10)
  always @(negedge clk) begin
    if (!rst && mem_wr)
      chk(in_op && !exp_err && (mem_wdata == exp_mem[mem_addr]), "R8",
          "write data", longint'(mem_wdata), longint'(exp_mem[mem_addr]));
    if (!rst && busy && !in_op)
      chk(1'b0, "R10", "busy outside an operation", 1, 0);
  end

  function automatic longint p10(input int n);
    longint r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  task automatic put_field(input int base, input int len, input longint val,
                           input bit neg, input bit [1:0] zf);
    for (int k = 0; k < len; k++) begin
      logic [3:0] d;
      d = 4'((val / p10(k)) % 10);
      mem[base + len - 1 - k] = (k == 0) ? {neg, zf[0], d} : {zf, d};
    end
  endtask

  task automatic model(input int aa, input int ac, input int ba, input int bc);
    int la, lb;
    longint va, vb, r, m, st;
    bit sa, sb, bad;
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    exp_err = 1'b0; exp_ovf = 1'b0; exp_neg = 1'b0;
    if (ac > 9 || bc > 9) begin exp_err = 1'b1; return; end
    la = (ac == 0) ? 10 : ac;
    lb = (bc == 0) ? 10 : bc;
    va = 0; vb = 0; bad = 1'b0;
    for (int k = 0; k < la; k++) begin
      if (mem[aa + la - 1 - k][3:0] > 9) bad = 1'b1;
      va = va + longint'(mem[aa + la - 1 - k][3:0]) * p10(k);
    end
    for (int k = 0; k < lb; k++) begin
      if (mem[ba + lb - 1 - k][3:0] > 9) bad = 1'b1;
      vb = vb + longint'(mem[ba + lb - 1 - k][3:0]) * p10(k);
    end
    if (bad) begin exp_err = 1'b1; return; end
    sa = mem[aa + la - 1][5];
    sb = mem[ba + lb - 1][5];
    r = (sa ? -va : va) + (sb ? -vb : vb);
    m = (r < 0) ? -r : r;
    exp_ovf = (m >= p10(lb));
    st = m % p10(lb);
    exp_neg = (r < 0) && (st != 0);
    for (int k = 0; k < lb; k++)
      exp_mem[ba + lb - 1 - k] = {(k == 0) && exp_neg, 1'b0, 4'((st / p10(k)) % 10)};
  endtask

  task automatic run_op(input string req, input int aa, input int ac,
                        input int ba, input int bc, input bit poke);
    int waited;
    model(aa, ac, ba, bc);
    @(negedge clk);
    a_addr = AW'(aa); a_len = 4'(ac); b_addr = AW'(ba); b_len = 4'(bc);
    start = 1'b1; in_op = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      a_addr = AW'(200); b_addr = AW'(210); a_len = 4'd2; b_len = 4'd2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, req, "done seen", longint'(done), 1);
    chk(err == exp_err, req, "err", longint'(err), longint'(exp_err));
    chk(ovf == exp_ovf, req, "ovf", longint'(ovf), longint'(exp_ovf));
    chk(res_neg == exp_neg, "R11", "res_neg", longint'(res_neg), longint'(exp_neg));
    @(negedge clk);
    chk(!done && !busy, "R10", "done single pulse", longint'(done), 0);
    in_op = 1'b0;
    for (int i = 0; i < 256; i++)
      if (mem[i] != exp_mem[i])
        chk(1'b0, req, $sformatf("memory at %0d", i), longint'(mem[i]), longint'(exp_mem[i]));
    chk(1'b1, req, "memory image", 0, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 6'(i % 10);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !ovf && !res_neg && !mem_rd && !mem_wr,
        "R10", "reset state", longint'({busy, done, err}), 0);

    put_field(10, 1, 1, 1'b1, 2'b00); put_field(20, 1, 8, 1'b0, 2'b00);
    run_op("R4", 10, 1, 20, 1, 1'b0);                       // 8 + -1 = 7
    put_field(10, 3, 456, 1'b0, 2'b00); put_field(20, 4, 1234, 1'b0, 2'b00);
    run_op("R3", 10, 3, 20, 4, 1'b0);                       // 1690
    put_field(10, 2, 99, 1'b1, 2'b00); put_field(20, 3, 12, 1'b1, 2'b00);
    run_op("R3", 10, 2, 20, 3, 1'b0);                       // -111
    put_field(10, 3, 500, 1'b1, 2'b00); put_field(20, 3, 123, 1'b0, 2'b00);
    run_op("R4", 10, 3, 20, 3, 1'b0);                       // -377, recomplement
    put_field(10, 3, 250, 1'b1, 2'b00); put_field(20, 3, 250, 1'b0, 2'b00);
    run_op("R5", 10, 3, 20, 3, 1'b0);                       // zero positive
    put_field(10, 3, 250, 1'b0, 2'b00); put_field(20, 3, 250, 1'b1, 2'b00);
    run_op("R5", 10, 3, 20, 3, 1'b0);
    put_field(10, 1, 7, 1'b0, 2'b00); put_field(20, 5, 93, 1'b1, 2'b00);
    run_op("R6", 10, 1, 20, 5, 1'b0);                       // -86
    put_field(10, 2, 60, 1'b0, 2'b00); put_field(20, 2, 55, 1'b0, 2'b00);
    run_op("R7", 10, 2, 20, 2, 1'b0);                       // 115 -> 15 ovf
    put_field(10, 4, 5000, 1'b1, 2'b00); put_field(20, 1, 3, 1'b0, 2'b00);
    run_op("R7", 10, 4, 20, 1, 1'b0);                       // -4997 -> -7 ovf
    put_field(30, 10, 64'd9999999999, 1'b0, 2'b00); put_field(50, 10, 1, 1'b0, 2'b00);
    run_op("R2", 30, 0, 50, 0, 1'b0);                       // ten digits, ovf, zero
    put_field(30, 10, 64'd1234567890, 1'b1, 2'b00); put_field(50, 10, 64'd9876543210, 1'b0, 2'b00);
    run_op("R2", 30, 0, 50, 0, 1'b0);                       // 8641975320
    put_field(10, 2, 21, 1'b0, 2'b11); put_field(20, 2, 30, 1'b0, 2'b01);
    mem[11] = {1'b0, 1'b1, 4'd1};
    run_op("R8", 10, 2, 20, 2, 1'b0);                       // zones ignored: 51
    put_field(10, 3, 123, 1'b0, 2'b00); put_field(20, 3, 456, 1'b0, 2'b00);
    mem[11] = 6'h0C;
    run_op("R9", 10, 3, 20, 3, 1'b0);                       // illegal digit in A
    put_field(10, 3, 123, 1'b0, 2'b00); mem[21] = 6'h3B;
    run_op("R9", 10, 3, 20, 3, 1'b0);                       // illegal digit in B
    put_field(20, 3, 456, 1'b0, 2'b00);
    run_op("R2", 10, 3, 20, 12, 1'b0);                      // illegal length code
    put_field(10, 2, 11, 1'b0, 2'b00); put_field(20, 2, 22, 1'b1, 2'b00);
    run_op("R10", 10, 2, 20, 2, 1'b1);                      // start while busy ignored
    put_field(60, 4, 4321, 1'b0, 2'b00); put_field(70, 2, 9, 1'b1, 2'b00);
    run_op("R1", 60, 4, 70, 2, 1'b0);                       // A kept, 4312 -> 12 ovf

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule